// File: doc/BRIEF.md
# Switch Monitor Serial Status and Interrupt Core

This block is the digital core of a multi-input switch monitor. It observes 22 switch states, already converted to logic levels and debounced: 8 inputs whose switch can go to either supply rail, and 14 inputs whose switch goes to ground. Each input reads 1 when its switch is closed. When an enabled input leaves the state the host last acknowledged, the block pulls its open-drain interrupt line low.

A host reads all switch states over an SPI slave port. The switch states are frozen into the shift register at the moment chip select goes low. The same frame carries a command word from the host to the block. The host can request sleep, control the tri-state of the input current sources, or write the per-input interrupt enable masks. The command takes effect only when chip select is released after a complete frame of exactly 24 clocks.

The interrupt is acknowledged implicitly. Releasing chip select clears it and adopts the captured states as the new reference, but only if no enabled input moved while the frame was open. The SPI pins are synchronised into the system clock domain, so SPI clock phases must last several system clocks.

Top module: `msdi_core`

## Requirements
- R1: After reset, the interrupt pull-down is off, `so_oe_o` is 0, `tri_en_o` is 0, `sleep_req_o` is 0, and every input is enabled for interrupts.
- R2: The states of all switch inputs are captured when chip select falls. The frame read is {interrupt-pending, thermal, sp_i[7:0], sg_i[13:0]}, from bit 23 down to bit 0, with 1 meaning closed. Input changes after the falling edge do not alter that frame.
- R3: When an enabled input differs from the reference snapshot, `int_low_o` rises to 1 within 3 clock cycles.
- R4: If an enabled input changes while chip select is low, the interrupt is asserted, and the rising edge of chip select does not clear it.
- R5: Serial-out sends bit 23 first and changes only after SCLK rising edges, never on falling edges. Serial-in is sampled on SCLK falling edges.
- R6: `so_oe_o` is 1 within 3 cycles of chip select going low, and 0 within 3 cycles of it going high.
- R7: Bit 22 of the read frame reflects `therm_i` at the chip-select falling edge.
- R8: A command is executed only if exactly 24 SCLK falling edges occurred while chip select was low. Frames with fewer or more edges change no output other than through the interrupt rule.
- R9: When no enabled input changed during a frame, chip-select release clears the interrupt, and the captured states become the new reference.
- R10: The command opcode occupies bits 23:20. Opcode 3 writes the enable mask of the 8 programmable inputs from bits 7:0. Opcode 4 writes the enable mask of the 14 ground inputs from bits 13:0. A mask bit of 1 enables the input. A change on a masked input raises no interrupt but still appears in the status read.
- R11: Opcode 1 produces exactly one single-cycle pulse on `sleep_req_o` after a valid frame.
- R12: Opcode 2 loads `tri_en_o` from command bit 0. Opcode 0 and the undefined opcodes have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | SPI chip select, active low |
| sclk_i | input | 1 | SPI clock, idles low |
| si_i | input | 1 | SPI serial data in |
| so_o | output | 1 | SPI serial data out |
| so_oe_o | output | 1 | Output enable for serial-out (0 = high impedance) |
| sp_i | input | 8 | Programmable-polarity switch states, 1 = closed |
| sg_i | input | 14 | Switch-to-ground states, 1 = closed |
| therm_i | input | 1 | Thermal warning flag |
| int_low_o | output | 1 | 1 pulls the open-drain interrupt line low |
| sleep_req_o | output | 1 | One-cycle sleep request |
| tri_en_o | output | 1 | Input current sources tri-stated when 1 |

## Verification
A stale reference snapshot shows first at `int_low_o`. Either the line fails to release after a clean frame, or it rises with no input moving, within four cycles of the chip-select edge. A corrupted capture or shift register appears in the very next frame read, bit for bit. A wrong frame-change flag inverts the hold-or-release decision at chip-select release. A miscounted clock edge either swallows a command or executes one from a truncated frame, and this is seen at `tri_en_o` or `sleep_req_o` a few cycles after release.

// File: rtl/msdi_pkg.sv
package msdi_pkg;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_READ   = 4'h0,
    OP_SLEEP  = 4'h1,
    OP_TRI    = 4'h2,
    OP_MASK_P = 4'h3,
    OP_MASK_G = 4'h4
  } op_e;
endpackage

// File: rtl/msdi_pin_sync.sv
module msdi_pin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q;

  always_comb chain_d = {chain_q[STAGES-2:0], d_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
      prev_q  <= RST_VAL;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign q_o    = chain_q[STAGES-1];
  assign rise_o = chain_q[STAGES-1] & ~prev_q;
  assign fall_o = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/msdi_frame_shifter.sv
module msdi_frame_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_fall_i,
  input  logic         cs_rise_i,
  input  logic         in_frame_i,
  input  logic         sclk_rise_i,
  input  logic         sclk_fall_i,
  input  logic         si_i,
  input  logic [W-1:0] status_i,
  output logic         so_o,
  output logic [W-1:0] rx_word_o,
  output logic         rx_valid_o
);
  localparam int CNT_W = $clog2(W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(W + 1);

  logic [W-1:0]     sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             so_q, so_d;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    so_d  = so_q;
    if (cs_fall_i) begin
      sh_d  = status_i;
      so_d  = status_i[W-1];
      cnt_d = '0;
    end else if (in_frame_i) begin
      if (sclk_fall_i) begin
        sh_d = {sh_q[W-2:0], si_i};
        if (cnt_q != CNT_OVER) cnt_d = cnt_q + 1'b1;
      end
      if (sclk_rise_i) so_d = sh_q[W-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      so_q  <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      so_q  <= so_d;
    end
  end

  assign so_o       = so_q;
  assign rx_word_o  = sh_q;
  assign rx_valid_o = cs_rise_i & (cnt_q == CNT_FULL);

  // R2: the first bit presented is the MSB of the captured status
  a_r2_load_msb: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall_i |=> (so_q == $past(status_i[W-1])));
  // R5: serial-out holds across SCLK falling edges
  a_r5_so_stable_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_fall_i && !cs_fall_i && !sclk_rise_i) |=> $stable(so_q));
endmodule

// File: rtl/msdi_change_irq.sv
module msdi_change_irq #(
  parameter int N = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sw_i,
  input  logic [N-1:0] mask_i,
  input  logic         cs_fall_i,
  input  logic         cs_rise_i,
  input  logic         in_frame_i,
  output logic         int_pend_o
);
  logic [N-1:0] ref_q, ref_d;
  logic [N-1:0] snap_q, snap_d;
  logic         chg_q, chg_d;
  logic         int_q, int_d;
  logic         diff_ref, diff_snap, release_now;

  always_comb begin
    diff_ref    = |((sw_i ^ ref_q) & mask_i);
    diff_snap   = |((sw_i ^ snap_q) & mask_i);
    release_now = cs_rise_i & ~(chg_q | diff_snap);

    snap_d = cs_fall_i ? sw_i : snap_q;
    chg_d  = chg_q;
    if (cs_fall_i)                    chg_d = 1'b0;
    else if (in_frame_i && diff_snap) chg_d = 1'b1;

    ref_d = release_now ? snap_q : ref_q;
    int_d = int_q;
    if (release_now)                                           int_d = 1'b0;
    else if (diff_ref || (in_frame_i && !cs_fall_i && diff_snap)) int_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      snap_q <= '0;
      chg_q  <= 1'b0;
      int_q  <= 1'b0;
    end else begin
      ref_q  <= ref_d;
      snap_q <= snap_d;
      chg_q  <= chg_d;
      int_q  <= int_d;
    end
  end

  assign int_pend_o = int_q;

  // R3: interrupt only rises when an enabled input has moved
  a_r3_rise_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_q) |-> ($past(diff_ref) || $past(diff_snap)));
  // R4: a change inside the frame survives chip-select release
  a_r4_hold_after_frame_change: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise_i && chg_q) |=> int_q);
  // R9: clean release drops the interrupt and adopts the snapshot
  a_r9_clean_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise_i && !chg_q && !diff_snap) |=> (!int_q && ref_q == $past(snap_q)));
endmodule

// File: rtl/msdi_cmd_decode.sv
module msdi_cmd_decode
  import msdi_pkg::*;
#(
  parameter int W    = 24,
  parameter int N_SP = 8,
  parameter int N_SG = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_valid_i,
  input  logic [W-1:0]    rx_word_i,
  output logic            sleep_req_o,
  output logic            tri_en_o,
  output logic [N_SP-1:0] mask_sp_o,
  output logic [N_SG-1:0] mask_sg_o
);
  logic            sleep_q, sleep_d;
  logic            tri_q, tri_d;
  logic [N_SP-1:0] msp_q, msp_d;
  logic [N_SG-1:0] msg_q, msg_d;
  op_e             op;

  always_comb begin
    op      = op_e'(rx_word_i[W-1 -: OP_W]);
    sleep_d = 1'b0;
    tri_d   = tri_q;
    msp_d   = msp_q;
    msg_d   = msg_q;
    if (rx_valid_i) begin
      case (op)
        OP_SLEEP:  sleep_d = 1'b1;
        OP_TRI:    tri_d   = rx_word_i[0];
        OP_MASK_P: msp_d   = rx_word_i[N_SP-1:0];
        OP_MASK_G: msg_d   = rx_word_i[N_SG-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
      tri_q   <= 1'b0;
      msp_q   <= '1;
      msg_q   <= '1;
    end else begin
      sleep_q <= sleep_d;
      tri_q   <= tri_d;
      msp_q   <= msp_d;
      msg_q   <= msg_d;
    end
  end

  assign sleep_req_o = sleep_q;
  assign tri_en_o    = tri_q;
  assign mask_sp_o   = msp_q;
  assign mask_sg_o   = msg_q;

  // R11: sleep request is a single-cycle pulse
  a_r11_sleep_single: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_q |=> !sleep_q);
  // R8: control state only moves after a full frame
  a_r8_tri_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid_i |=> $stable(tri_q));
endmodule

// File: rtl/msdi_core.sv
module msdi_core #(
  parameter int N_SP        = 8,
  parameter int N_SG        = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs_n_i,
  input  logic            sclk_i,
  input  logic            si_i,
  output logic            so_o,
  output logic            so_oe_o,
  input  logic [N_SP-1:0] sp_i,
  input  logic [N_SG-1:0] sg_i,
  input  logic            therm_i,
  output logic            int_low_o,
  output logic            sleep_req_o,
  output logic            tri_en_o
);
  localparam int N_SW = N_SP + N_SG;
  localparam int W    = N_SW + 2;

  logic            cs_s, cs_rise, cs_fall;
  logic            sclk_s, sclk_rise, sclk_fall;
  logic            si_s, si_rise_unused, si_fall_unused;
  logic            in_frame, int_pend, rx_valid;
  logic [N_SW-1:0] sw_now, mask_all;
  logic [N_SP-1:0] mask_sp;
  logic [N_SG-1:0] mask_sg;
  logic [W-1:0]    status, rx_word;

  msdi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs (
    .clk(clk), .rst_n(rst_n), .d_i(cs_n_i),
    .q_o(cs_s), .rise_o(cs_rise), .fall_o(cs_fall));

  msdi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sclk (
    .clk(clk), .rst_n(rst_n), .d_i(sclk_i),
    .q_o(sclk_s), .rise_o(sclk_rise), .fall_o(sclk_fall));

  msdi_pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_si (
    .clk(clk), .rst_n(rst_n), .d_i(si_i),
    .q_o(si_s), .rise_o(si_rise_unused), .fall_o(si_fall_unused));

  assign in_frame = ~cs_s;
  assign sw_now   = {sp_i, sg_i};
  assign mask_all = {mask_sp, mask_sg};
  assign status   = {int_pend, therm_i, sw_now};

  msdi_change_irq #(.N(N_SW)) u_irq (
    .clk(clk), .rst_n(rst_n), .sw_i(sw_now), .mask_i(mask_all),
    .cs_fall_i(cs_fall), .cs_rise_i(cs_rise), .in_frame_i(in_frame),
    .int_pend_o(int_pend));

  msdi_frame_shifter #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .in_frame_i(in_frame), .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
    .si_i(si_s), .status_i(status), .so_o(so_o),
    .rx_word_o(rx_word), .rx_valid_o(rx_valid));

  msdi_cmd_decode #(.W(W), .N_SP(N_SP), .N_SG(N_SG)) u_cmd (
    .clk(clk), .rst_n(rst_n), .rx_valid_i(rx_valid), .rx_word_i(rx_word),
    .sleep_req_o(sleep_req_o), .tri_en_o(tri_en_o),
    .mask_sp_o(mask_sp), .mask_sg_o(mask_sg));

  assign so_oe_o   = in_frame;
  assign int_low_o = int_pend;

  // R6: output enable drops only while synchronized chip select is high
  a_r6_oe_follows_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(so_oe_o) |-> $past(cs_n_i, 1) || $past(cs_n_i, 2) || cs_n_i);
  // R8: a command is accepted only at chip-select release
  a_r8_accept_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (cs_s && $past(!cs_s)));
endmodule

// File: tb/tb_msdi_core.sv
module tb_msdi_core;
  localparam int HALF = 6;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cs_n, sclk, si;
  logic        so, so_oe, int_low, sleep_req, tri_en;
  logic [7:0]  sp;
  logic [13:0] sg;
  logic        therm;

  int n_cmp = 0;
  int n_bad = 0;
  int sleep_cnt = 0;
  bit done = 0;

  logic [23:0] exp_q[$];
  string       tag_q[$];
  logic [23:0] got_q[$];

  always #5 clk = ~clk;

  msdi_core dut (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .si_i(si),
    .so_o(so), .so_oe_o(so_oe), .sp_i(sp), .sg_i(sg), .therm_i(therm),
    .int_low_o(int_low), .sleep_req_o(sleep_req), .tri_en_o(tri_en));

  always @(negedge clk) if (rst_n && sleep_req) sleep_cnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops received frames and compares with predicted ones
  initial begin
    forever begin
      @(negedge clk);
      while (got_q.size() > 0 && exp_q.size() > 0) begin
        logic [23:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {8'h0, g}, {8'h0, e});
      end
    end
  end

  function automatic logic [23:0] st(input logic ip);
    return {ip, therm, sp, sg};
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: one SPI frame; predicted status pushed when cmp is set
  task automatic spi(input logic [23:0] cmd, input int nclk, input bit cmp,
                     input logic [23:0] exp, input string tag,
                     input int chg_bit, input logic [13:0] chg_mask);
    logic [23:0] rx;
    logic        smp;
    bit          edge_ok;
    rx = '0;
    edge_ok = 1;
    if (cmp) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    cs_n = 1'b0;
    wait_clk(HALF);
    chk("R6 oe in frame", {31'h0, so_oe}, 32'h1);
    for (int i = 0; i < nclk; i++) begin
      sclk = 1'b1;
      si = (i < 24) ? cmd[23-i] : 1'b0;
      if (i == chg_bit) sg = sg ^ chg_mask;
      wait_clk(HALF);
      smp = so;
      if (i < 24) rx[23-i] = smp;
      sclk = 1'b0;
      wait_clk(HALF);
      if (so !== smp) edge_ok = 0;
    end
    chk("R5 so steady over falling edge", {31'h0, edge_ok}, 32'h1);
    cs_n = 1'b1;
    wait_clk(HALF);
    chk("R6 oe off after frame", {31'h0, so_oe}, 32'h0);
    if (cmp) got_q.push_back(rx);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int s0;
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; si = 1'b0;
    sp = '0; sg = '0; therm = 1'b0;
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    // R1 reset state
    chk("R1 int", {31'h0, int_low}, 32'h0);
    chk("R1 oe", {31'h0, so_oe}, 32'h0);
    chk("R1 tri", {31'h0, tri_en}, 32'h0);
    chk("R1 sleep", sleep_cnt, 0);

    // R2 plain read, all open
    spi(24'h000000, 24, 1, st(1'b0), "R2 idle read", -1, '0);

    // R3 enabled change raises interrupt
    sp = 8'h81; sg = 14'h0003;
    wait_clk(4);
    chk("R3 int after change", {31'h0, int_low}, 32'h1);
    // R2 read with pending flag set, R9 release afterwards
    spi(24'h000000, 24, 1, st(1'b1), "R2 read closed switches", -1, '0);
    chk("R9 int released", {31'h0, int_low}, 32'h0);

    // R4 change in frame; R2 snapshot unaffected
    spi(24'h000000, 24, 1, st(1'b0), "R2 frozen snapshot", 5, 14'h0020);
    chk("R4 int held after release", {31'h0, int_low}, 32'h1);
    spi(24'h000000, 24, 1, st(1'b1), "R4 follow-up read", -1, '0);
    chk("R9 int released after clean frame", {31'h0, int_low}, 32'h0);

    // R7 thermal flag
    therm = 1'b1;
    spi(24'h000000, 24, 1, st(1'b0), "R7 thermal bit", -1, '0);
    therm = 1'b0;

    // R10 masks: disable sg[2] and sp[7]
    spi(24'h403FFB, 24, 1, st(1'b0), "R10 mask frame read", -1, '0);
    spi(24'h30007F, 24, 1, st(1'b0), "R10 mask frame read 2", -1, '0);
    sg = sg ^ 14'h0004;
    wait_clk(6);
    chk("R10 masked sg no int", {31'h0, int_low}, 32'h0);
    sp = sp ^ 8'h80;
    wait_clk(6);
    chk("R10 masked sp no int", {31'h0, int_low}, 32'h0);
    spi(24'h000000, 24, 1, st(1'b0), "R10 masked inputs still read", -1, '0);
    spi(24'h403FFF, 24, 0, '0, "", -1, '0);
    spi(24'h3000FF, 24, 0, '0, "", -1, '0);
    sg = sg ^ 14'h0004;
    wait_clk(6);
    chk("R10 re-enabled sg raises int", {31'h0, int_low}, 32'h1);
    spi(24'h000000, 24, 1, st(1'b1), "R10 read after unmask", -1, '0);

    // R8 short and long frames discarded; R11 sleep pulse
    s0 = sleep_cnt;
    spi(24'h100000, 20, 0, '0, "", -1, '0);
    spi(24'h100000, 25, 0, '0, "", -1, '0);
    chk("R8 no sleep from bad frames", sleep_cnt - s0, 0);
    spi(24'h100000, 24, 1, st(1'b0), "R11 sleep frame read", -1, '0);
    chk("R11 one sleep pulse", sleep_cnt - s0, 1);

    // R12 tri-state control
    spi(24'h200001, 24, 0, '0, "", -1, '0);
    chk("R12 tri set", {31'h0, tri_en}, 32'h1);
    spi(24'h200000, 23, 0, '0, "", -1, '0);
    chk("R8 tri kept on short frame", {31'h0, tri_en}, 32'h1);
    spi(24'hF00000, 24, 0, '0, "", -1, '0);
    chk("R12 undefined opcode ignored", {31'h0, tri_en}, 32'h1);
    spi(24'h000000, 24, 0, '0, "", -1, '0);
    chk("R12 read opcode ignored", {31'h0, tri_en}, 32'h1);
    spi(24'h200000, 24, 0, '0, "", -1, '0);
    chk("R12 tri cleared", {31'h0, tri_en}, 32'h0);

    wait_clk(4);
    chk("R2 all frames compared", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule